// File: doc/BRIEF.md
# Cartridge Bank Remapping Address Decoder

This block sorts each 24-bit CPU address (an 8-bit bank and a 16-bit offset) into one of the cartridge targets: the removable memory pack, a 512 KB pseudo-static RAM, the boot ROM, an open-bus hole, or nothing at all. It also returns a hit flag and, when the target is the RAM, the byte address inside that RAM. A 16-bit control word, taken from the cartridge's configuration latches, sets the layout. One bit picks the page mode: 32 KB pages or 64 KB pages. The other bits switch each region on for the lower or upper half of the bank space, or move the RAM and hole windows to another base bank.

Regions may overlap, and a fixed priority settles which one wins. The decode is combinational. A single register stage, reset synchronously, holds the target code, the hit flag and the RAM address. The result for the inputs present at a rising clock edge therefore appears just after that edge. Control bits 0, 1 and 12 to 15 have no effect.

Top module: `cart_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `tgt_sel` = 0, `hit` = 0 and `ram_addr` = 0.
- R2: The target codes are 0 = none, 1 = memory pack, 2 = hole, 3 = RAM and 4 = boot ROM. `hit` is 1 exactly when the code is nonzero. The outputs after a rising edge reflect the inputs sampled at that edge and stay unchanged until the next edge.
- R3: With `ctrl[2]` = 0 (32 KB-page mode), the pack answers at offsets 0x8000 and above in banks 0x00–0x7D and 0x80–0xFF. It also answers at offsets below 0x8000 in banks 0x40–0x7D and 0xC0–0xFF.
- R4: With `ctrl[2]` = 1 (64 KB-page mode), the pack answers at offsets 0x8000 and above in banks 0x00–0x3F and 0x80–0xBF, and at every offset in banks 0x40–0x7D and 0xC0–0xFF.
- R5: In 32 KB-page mode, let S = 0x20·`ctrl[5]` + 0x40·`ctrl[6]`. `ctrl[3]` maps RAM to banks S to S+0x0F and `ctrl[4]` maps it to banks 0x80+S to 0x8F+S. Both windows start at offset 0 when `ctrl[6]` = 1 and at 0x8000 otherwise. `ctrl[3]` also maps RAM to offsets below 0x8000 of banks 0x70–0x7D, and `ctrl[4]` does the same for banks 0xF0–0xFF.
- R6: In 64 KB-page mode, let B = 0x10·`ctrl[5]` + 0x20·`ctrl[6]`. `ctrl[3]` maps RAM to offsets 0x8000 and above of banks B to B+7, to all of banks 0x40+B to 0x47+B, and to offsets 0x6000–0x7FFF of banks 0x20–0x3F. `ctrl[4]` maps the same three windows with 0x80 added to each bank.
- R7: In 32 KB-page mode, let H = 0x40·`ctrl[11]`. `ctrl[9]` places the hole at banks H to H+0x1F and `ctrl[10]` places it at banks 0x80+H to 0x9F+H. The hole starts at offset 0 when `ctrl[11]` = 1 and at 0x8000 otherwise.
- R8: In 64 KB-page mode, let H = 0x20·`ctrl[11]`. `ctrl[9]` places the hole at offsets 0x8000 and above of banks H to H+0x0F and at every offset of banks 0x40+H to 0x4F+H. `ctrl[10]` does the same with 0x80 added to each bank.
- R9: In both modes, `ctrl[7]` maps the boot ROM to offsets 0x8000 and above of banks 0x00–0x3F, and `ctrl[8]` does the same for banks 0x80–0xBF. The boot ROM overrides every other region.
- R10: Where regions overlap, RAM beats the hole and the hole beats the pack.
- R11: For a RAM hit, `ram_addr` is {bank[2:0], offset} in 64 KB-page mode. It takes the same form in 32 KB-page mode for the base-bank window when `ctrl[6]` = 1. Every other 32 KB-page RAM hit gives {bank[3:0], offset[14:0]}. `ram_addr` is 0 when the target is not RAM.
- R12: Banks 0x7E and 0x7F give target none in every mode and for every control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank | input | 8 | CPU address bits 23:16 |
| off | input | 16 | CPU address bits 15:0 |
| ctrl | input | 16 | Control word; bit n is latch n |
| tgt_sel | output | 3 | Selected target code (R2) |
| hit | output | 1 | A region matched |
| ram_addr | output | 19 | RAM byte address, modulo 512 KB |

## Verification
The assertions take for granted that `bank`, `off` and `ctrl` are known, not X, at every clock edge after reset. They also take for granted that reset is released only on a clock edge, because several properties link the outputs to the inputs of the previous cycle. The stimulus meets both conditions: it changes inputs only on falling edges, it drives every input bit from time zero, and in the random sweep every control word is a full 16-bit value, so unused bits and overlapping windows are exercised as well.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_PACK = 3'd1,
    TGT_HOLE = 3'd2,
    TGT_RAM  = 3'd3,
    TGT_BOOT = 3'd4
  } tgt_e;

  // control word bit positions
  localparam int C_MODE    = 2;
  localparam int C_RAM_LO  = 3;
  localparam int C_RAM_HI  = 4;
  localparam int C_RBASE_A = 5;
  localparam int C_RBASE_B = 6;
  localparam int C_BOOT_LO = 7;
  localparam int C_BOOT_HI = 8;
  localparam int C_HOLE_LO = 9;
  localparam int C_HOLE_HI = 10;
  localparam int C_HBASE   = 11;

  // region matches from one page-mode map
  typedef struct packed {
    logic pack;
    logic hole;
    logic ram;
    logic ram_full;  // RAM window uses whole 64 KB banks
  } area_t;

endpackage

// File: rtl/cdec_page32.sv
module cdec_page32
  import cdec_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic [BANK_W-1:0] bank,
  input  logic              upper,
  input  logic [1:0]        ram_en,
  input  logic [1:0]        rbase,
  input  logic [1:0]        hole_en,
  input  logic              hbase,
  output area_t             area
);
  localparam int HB = BANK_W - 1;

  logic [1:0] hole_w, ram_w, full_w;

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam bit NO_CAP = (g == 1);
    logic in_half, prim, tail;
    assign in_half = (bank[HB] == 1'(g));
    assign hole_w[g] = hole_en[g] && in_half && (bank[HB-1] == hbase)
                       && !bank[HB-2] && (hbase || upper);
    assign prim = ram_en[g] && in_half && (bank[HB-1:HB-2] == rbase)
                  && !bank[HB-3] && (rbase[1] || upper);
    assign tail = ram_en[g] && in_half && (bank[HB-1:HB-3] == 3'b111)
                  && !upper && (NO_CAP || bank[3:0] <= 4'hD);
    assign ram_w[g]  = prim || tail;
    assign full_w[g] = prim && rbase[1];
  end

  always_comb begin
    if (upper) area.pack = bank[HB] || (bank[HB-1:0] <= 7'h7D);
    else       area.pack = bank[HB-1] && (bank[HB] || bank[HB-2:0] <= 6'h3D);
    area.hole     = |hole_w;
    area.ram      = |ram_w;
    area.ram_full = |full_w;
  end

endmodule

// File: rtl/cdec_page64.sv
module cdec_page64
  import cdec_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic [BANK_W-1:1] bank_hi,
  input  logic [2:0]        off_top,
  input  logic [1:0]        ram_en,
  input  logic [1:0]        rbase,
  input  logic [1:0]        hole_en,
  input  logic              hbase,
  output area_t             area
);
  localparam int HB = BANK_W - 1;

  logic       upper;
  logic [1:0] hole_w, ram_w;

  assign upper = off_top[2];

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic in_half, base_ok, w_up, w_full, w_mid;
    assign in_half = (bank_hi[HB] == 1'(g));
    assign hole_w[g] = hole_en[g] && in_half && (bank_hi[HB-2] == hbase)
                       && !bank_hi[HB-3] && (bank_hi[HB-1] || upper);
    assign base_ok = (bank_hi[HB-2:HB-3] == rbase) && !bank_hi[HB-4];
    assign w_up   = !bank_hi[HB-1] && base_ok && upper;
    assign w_full = bank_hi[HB-1] && base_ok;
    assign w_mid  = (bank_hi[HB-1:HB-2] == 2'b01) && (off_top == 3'b011);
    assign ram_w[g] = ram_en[g] && in_half && (w_up || w_full || w_mid);
  end

  always_comb begin
    area.pack     = (upper || bank_hi[HB-1]) && (bank_hi != 7'h3F);
    area.hole     = |hole_w;
    area.ram      = |ram_w;
    area.ram_full = |ram_w;
  end

endmodule

// File: rtl/cdec_prio.sv
module cdec_prio
  import cdec_pkg::*;
(
  input  area_t area,
  input  logic  boot,
  output tgt_e  tgt,
  output logic  hit
);
  always_comb begin
    if (boot)           tgt = TGT_BOOT;
    else if (area.ram)  tgt = TGT_RAM;
    else if (area.hole) tgt = TGT_HOLE;
    else if (area.pack) tgt = TGT_PACK;
    else                tgt = TGT_NONE;
    hit = boot || area.ram || area.hole || area.pack;
  end
endmodule

// File: rtl/cart_decoder.sv
module cart_decoder
  import cdec_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int CTRL_W = 16,
  parameter int RAM_AW = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [2:0]        tgt_sel,
  output logic              hit,
  output logic [RAM_AW-1:0] ram_addr
);
  localparam int PAGE_W  = OFF_W - 1;
  localparam int FULL_BB = RAM_AW - OFF_W;
  localparam int HALF_BB = RAM_AW - PAGE_W;

  logic upper, boot, unused_ctrl;
  area_t a32, a64, area;
  tgt_e tgt_c;
  logic hit_c;
  logic [RAM_AW-1:0] addr_c;

  assign unused_ctrl = ^{ctrl[1:0], ctrl[CTRL_W-1:C_HBASE+1]};
  assign upper = off[OFF_W-1];

  cdec_page32 #(.BANK_W(BANK_W)) u_p32 (
    .bank    (bank),
    .upper   (upper),
    .ram_en  ({ctrl[C_RAM_HI], ctrl[C_RAM_LO]}),
    .rbase   ({ctrl[C_RBASE_B], ctrl[C_RBASE_A]}),
    .hole_en ({ctrl[C_HOLE_HI], ctrl[C_HOLE_LO]}),
    .hbase   (ctrl[C_HBASE]),
    .area    (a32)
  );

  cdec_page64 #(.BANK_W(BANK_W)) u_p64 (
    .bank_hi (bank[BANK_W-1:1]),
    .off_top (off[OFF_W-1:OFF_W-3]),
    .ram_en  ({ctrl[C_RAM_HI], ctrl[C_RAM_LO]}),
    .rbase   ({ctrl[C_RBASE_B], ctrl[C_RBASE_A]}),
    .hole_en ({ctrl[C_HOLE_HI], ctrl[C_HOLE_LO]}),
    .hbase   (ctrl[C_HBASE]),
    .area    (a64)
  );

  assign area = ctrl[C_MODE] ? a64 : a32;
  assign boot = upper && !bank[BANK_W-2]
                && (bank[BANK_W-1] ? ctrl[C_BOOT_HI] : ctrl[C_BOOT_LO]);

  cdec_prio u_prio (
    .area (area),
    .boot (boot),
    .tgt  (tgt_c),
    .hit  (hit_c)
  );

  always_comb begin
    if (tgt_c != TGT_RAM)  addr_c = '0;
    else if (area.ram_full) addr_c = {bank[FULL_BB-1:0], off};
    else                    addr_c = {bank[HALF_BB-1:0], off[PAGE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sel  <= TGT_NONE;
      hit      <= 1'b0;
      ram_addr <= '0;
    end else begin
      tgt_sel  <= tgt_c;
      hit      <= hit_c;
      ram_addr <= addr_c;
    end
  end

endmodule

// File: rtl/cdec_chk.sv
module cdec_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  bank,
  input logic [15:0] off,
  input logic [15:0] ctrl,
  input logic [2:0]  tgt_sel,
  input logic        hit,
  input logic [18:0] ram_addr
);
  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (tgt_sel == 3'd0 && !hit && ram_addr == 19'd0));

  p_hit_code_r2: assert property (@(posedge clk) disable iff (rst || !seen)
    hit == (tgt_sel != 3'd0));

  p_addr_quiet_r11: assert property (@(posedge clk) disable iff (rst || !seen)
    (tgt_sel != 3'd3) |-> (ram_addr == 19'd0));

  p_boot_wins_r9: assert property (@(posedge clk) disable iff (rst || !seen)
    ($past(ctrl[7]) && $past(bank) < 8'h40 && $past(off[15])) |-> (tgt_sel == 3'd4));

  p_dead_banks_r12: assert property (@(posedge clk) disable iff (rst || !seen)
    ($past(bank[7:1]) == 7'h3F) |-> (tgt_sel == 3'd0));

  p_pack_hi_r3: assert property (@(posedge clk) disable iff (rst || !seen)
    ($past(ctrl[2]) == 1'b0 && $past(ctrl[4]) == 1'b0 && $past(ctrl[8]) == 1'b0
     && $past(ctrl[10]) == 1'b0 && $past(bank[7]) && $past(off[15]))
    |-> (tgt_sel == 3'd1));

endmodule

bind cart_decoder cdec_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bank     (bank),
  .off      (off),
  .ctrl     (ctrl),
  .tgt_sel  (tgt_sel),
  .hit      (hit),
  .ram_addr (ram_addr)
);

// File: tb/sim_cart_decoder.sv
`timescale 1ns/1ps
module sim_cart_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bank = '0;
  logic [15:0] off = '0;
  logic [15:0] ctrl = '0;
  logic [2:0]  tgt_sel;
  logic        hit;
  logic [18:0] ram_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_decoder u0 (
    .clk(clk), .rst(rst), .bank(bank), .off(off), .ctrl(ctrl),
    .tgt_sel(tgt_sel), .hit(hit), .ram_addr(ram_addr)
  );

  // behavioural reference built from the requirements, lowest priority first
  function automatic logic [21:0] model(int b, int o, logic [15:0] c);
    int t = 0;
    int a = 0;
    bit up = (o >= 32768);
    if (!c[2]) begin
      int hb = c[11] ? 'h40 : 0;
      int hs = c[11] ? 0 : 'h8000;
      int rs = (c[5] ? 'h20 : 0) + (c[6] ? 'h40 : 0);
      int ro = c[6] ? 0 : 'h8000;
      if ((b <= 'h7D || b >= 'h80) && up) t = 1;
      if (((b >= 'h40 && b <= 'h7D) || b >= 'hC0) && !up) t = 1;
      if (c[9] && b >= hb && b <= hb + 'h1F && o >= hs) t = 2;
      if (c[10] && b >= 'h80 + hb && b <= 'h9F + hb && o >= hs) t = 2;
      for (int h = 0; h < 2; h++) begin
        int ofs = h * 'h80;
        if (c[3 + h]) begin
          if (b >= rs + ofs && b <= rs + ofs + 15 && o >= ro) begin
            t = 3;
            a = c[6] ? ((b - rs - ofs) * 65536 + o) % 524288
                     : ((b - rs - ofs) * 32768 + o - 32768) % 524288;
          end
          if (b >= 'h70 + ofs && b <= (h == 1 ? 'hFF : 'h7D) && !up) begin
            t = 3;
            a = (b - 'h70 - ofs) * 32768 + o;
          end
        end
      end
    end else begin
      int hb = c[11] ? 'h20 : 0;
      int rb = (c[5] ? 'h10 : 0) + (c[6] ? 'h20 : 0);
      if ((b <= 'h3F || (b >= 'h80 && b <= 'hBF)) && up) t = 1;
      if ((b >= 'h40 && b <= 'h7D) || b >= 'hC0) t = 1;
      for (int h = 0; h < 2; h++) begin
        int ofs = h * 'h80;
        if (c[9 + h] && b >= hb + ofs && b <= hb + ofs + 15 && up) t = 2;
        if (c[9 + h] && b >= 'h40 + hb + ofs && b <= 'h4F + hb + ofs) t = 2;
        if (c[3 + h]) begin
          if (b >= rb + ofs && b <= rb + ofs + 7 && up) begin
            t = 3; a = (b - rb - ofs) * 65536 + o;
          end
          if (b >= 'h40 + rb + ofs && b <= 'h47 + rb + ofs) begin
            t = 3; a = (b - 'h40 - rb - ofs) * 65536 + o;
          end
          if (b >= 'h20 + ofs && b <= 'h3F + ofs && o >= 'h6000 && o <= 'h7FFF) begin
            t = 3; a = ((b - 'h20 - ofs) * 65536 + o) % 524288;
          end
        end
      end
    end
    if (c[7] && b <= 'h3F && up) t = 4;
    if (c[8] && b >= 'h80 && b <= 'hBF && up) t = 4;
    if (t != 3) a = 0;
    return {3'(t), 19'(a)};
  endfunction

  task automatic expect_out(string rq, logic [2:0] et, logic [18:0] ea);
    n_chk++;
    if (tgt_sel !== et || hit !== (et != 3'd0) || ram_addr !== ea) begin
      n_bad++;
      $display("FAIL %s: tgt=%0d hit=%0b addr=%h, expected tgt=%0d hit=%0b addr=%h",
               rq, tgt_sel, hit, ram_addr, et, (et != 3'd0), ea);
    end
  endtask

  task automatic probe(string rq, logic [7:0] b, logic [15:0] o, logic [15:0] c,
                       logic [2:0] et, logic [18:0] ea);
    @(negedge clk);
    bank = b; off = o; ctrl = c;
    @(posedge clk); #1;
    expect_out(rq, et, ea);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    bank = 8'h00; off = 16'h8000; ctrl = 16'h0080;
    repeat (3) @(posedge clk);
    #1 expect_out("R1 reset state", 3'd0, 19'd0);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_pack32;
    probe("R3 low bank upper half",  8'h00, 16'h8000, 16'h0000, 3'd1, 19'd0);
    probe("R3 low bank lower half",  8'h00, 16'h1234, 16'h0000, 3'd0, 19'd0);
    probe("R3 bank 45 lower half",   8'h45, 16'h0100, 16'h0000, 3'd1, 19'd0);
    probe("R3 bank C3 lower half",   8'hC3, 16'h0000, 16'h0000, 3'd1, 19'd0);
    probe("R3 bank 85 lower half",   8'h85, 16'h7FFF, 16'h0000, 3'd0, 19'd0);
    probe("R12 bank 7E in 32K mode", 8'h7E, 16'h9000, 16'h0000, 3'd0, 19'd0);
  endtask

  task automatic t_pack64;
    probe("R4 bank 10 lower",  8'h10, 16'h2000, 16'h0004, 3'd0, 19'd0);
    probe("R4 bank 10 upper",  8'h10, 16'h8000, 16'h0004, 3'd1, 19'd0);
    probe("R4 bank 50 full",   8'h50, 16'h0000, 16'h0004, 3'd1, 19'd0);
    probe("R4 bank D0 full",   8'hD0, 16'h1234, 16'h0004, 3'd1, 19'd0);
    probe("R4 bank 90 lower",  8'h90, 16'h4000, 16'h0004, 3'd0, 19'd0);
    probe("R12 bank 7F in 64K mode", 8'h7F, 16'h0000, 16'hFFFF, 3'd0, 19'd0);
  endtask

  task automatic t_ram32;
    probe("R5 window at 20 upper", 8'h25, 16'h9234, 16'h0028, 3'd3, 19'h29234);
    probe("R5 window at 20 lower", 8'h25, 16'h1234, 16'h0028, 3'd0, 19'd0);
    probe("R5 tail bank 72",       8'h72, 16'h0010, 16'h0028, 3'd3, 19'h10010);
    probe("R5 upper side off",     8'hA5, 16'h9234, 16'h0028, 3'd1, 19'd0);
    probe("R11 full-bank window",  8'h43, 16'h1234, 16'h0048, 3'd3, 19'h31234);
    probe("R11 full-bank upper",   8'h43, 16'h9234, 16'h0048, 3'd3, 19'h39234);
    probe("R5 beyond window",      8'h50, 16'h1234, 16'h0048, 3'd1, 19'd0);
  endtask

  task automatic t_ram64;
    probe("R6 base window upper", 8'h13, 16'h8005, 16'h003C, 3'd3, 19'h38005);
    probe("R6 base window lower", 8'h13, 16'h0005, 16'h003C, 3'd0, 19'd0);
    probe("R6 full bank window",  8'h55, 16'h0100, 16'h003C, 3'd3, 19'h50100);
    probe("R6 middle window",     8'h2A, 16'h6001, 16'h003C, 3'd3, 19'h26001);
    probe("R6 below middle",      8'h2A, 16'h5FFF, 16'h003C, 3'd0, 19'd0);
    probe("R6 mirror upper",      8'h93, 16'h8000, 16'h003C, 3'd3, 19'h38000);
    probe("R6 mirror middle",     8'hA1, 16'h7FFF, 16'h003C, 3'd3, 19'h17FFF);
    probe("R6 past mirror full",  8'hD8, 16'h0000, 16'h003C, 3'd1, 19'd0);
  endtask

  task automatic t_hole32;
    probe("R7 low hole at 05",     8'h05, 16'h8000, 16'h0200, 3'd2, 19'd0);
    probe("R7 bank 25 not hole",   8'h25, 16'h8000, 16'h0200, 3'd1, 19'd0);
    probe("R7 moved hole lower",   8'h41, 16'h0001, 16'h0A00, 3'd2, 19'd0);
    probe("R7 old window free",    8'h05, 16'h8000, 16'h0A00, 3'd1, 19'd0);
    probe("R7 upper hole moved",   8'hC2, 16'h0000, 16'h0C00, 3'd2, 19'd0);
    probe("R7 upper hole off",     8'hC2, 16'h0000, 16'h0200, 3'd1, 19'd0);
  endtask

  task automatic t_hole64;
    probe("R8 hole upper half",  8'h0F, 16'h8000, 16'h0204, 3'd2, 19'd0);
    probe("R8 hole lower half",  8'h0F, 16'h0000, 16'h0204, 3'd0, 19'd0);
    probe("R8 hole full bank",   8'h4A, 16'h0010, 16'h0204, 3'd2, 19'd0);
    probe("R8 past hole",        8'h50, 16'h0010, 16'h0204, 3'd1, 19'd0);
    probe("R8 moved upper hole", 8'hAF, 16'h9000, 16'h0C04, 3'd2, 19'd0);
    probe("R8 moved full hole",  8'hEF, 16'h0000, 16'h0C04, 3'd2, 19'd0);
  endtask

  task automatic t_prio;
    probe("R10 RAM over hole",  8'h08, 16'h8000, 16'h0208, 3'd3, 19'h40000);
    probe("R10 hole over pack", 8'h18, 16'h8000, 16'h0208, 3'd2, 19'd0);
  endtask

  task automatic t_boot;
    probe("R9 boot over RAM and hole", 8'h08, 16'h8000, 16'h0288, 3'd4, 19'd0);
    probe("R9 boot lower half",        8'h08, 16'h0000, 16'h0288, 3'd0, 19'd0);
    probe("R9 boot upper side 64K",    8'h80, 16'h8000, 16'h0114, 3'd4, 19'd0);
    probe("R9 lower half 64K",         8'h80, 16'h0000, 16'h0114, 3'd0, 19'd0);
  endtask

  task automatic t_latency;
    probe("R2 first value", 8'h25, 16'h9234, 16'h0028, 3'd3, 19'h29234);
    @(negedge clk);
    bank = 8'h7E; off = 16'h0000; ctrl = 16'h0000;
    #1 expect_out("R2 held until edge", 3'd3, 19'h29234);
    @(posedge clk); #1;
    expect_out("R2 next value", 3'd0, 19'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  b = 8'($urandom);
      logic [15:0] o = 16'($urandom);
      logic [15:0] c = 16'($urandom);
      logic [21:0] m = model(int'(b), int'(o), c);
      probe("R10 random sweep", b, o, c, m[21:19], m[18:0]);
    end
  endtask

  initial begin
    t_reset;
    t_pack32;
    t_pack64;
    t_ram32;
    t_ram64;
    t_hole32;
    t_hole64;
    t_prio;
    t_boot;
    t_latency;
    t_random;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule